// File: doc/BRIEF.md
# Real-Time Tick Generator with Keyed Watchdog

This block runs entirely on the slow low-frequency clock, nominally 32.768 kHz. A free-running divider chain gives a set of power-of-two taps. Software picks one tap for the periodic real-time tick. Each tick sets a sticky interrupt flag and can also pulse a wake request toward the wake-up controller, so the part can leave power-save mode. A second, fixed tap of the same chain paces the watchdog.

The watchdog stays idle until software starts it, and after that only its own expiry stops it. While it runs, software must write a fixed service key to the service register. A write counts as a valid service only if it comes after the lower window bound, which is a quarter of the timeout, and before the timeout. A missed deadline, a write with the wrong key, or a service that comes too early is a watchdog error. An error makes the block issue a fixed-length reset request, sets a sticky cause bit and puts the watchdog back in the idle state.

Software reaches the block through a small write strobe and a combinational read port with four 2-bit addresses: 0 control, 1 status, 2 start, 3 service.

Top module: `rtc_wdog`

## Requirements
- R1: The tick period is 2^(8+sel) slow-clock cycles, where sel is control bits [2:0]. sel=0 gives 256 cycles and sel=7 gives 32768 cycles.
- R2: When control bit 4 (wake enable) is 1, wake_o pulses high for exactly one cycle on each tick. When that bit is 0, wake_o stays low.
- R3: Each tick sets status bit 0, and that bit stays set until software writes a 1 to it; writing a 0 leaves it set. irq_o equals status bit 0 ANDed with control bit 3 (interrupt enable).
- R4: After reset the watchdog is idle and status bit 1 reads 0. While it is idle, writes to the service address have no effect: no reset request is raised, and the count read at address 3 stays 0.
- R5: Writing to address 2 with bit 0 set starts the watchdog. After that, no register write stops it, including writes of 0 to address 2.
- R6: If 16 watchdog ticks (each 256 cycles) pass without a valid service, the block raises a reset request.
- R7: While the watchdog runs, writing any value other than the key 0xA5 to address 3 raises a reset request at the next clock edge.
- R8: While the watchdog runs, a key write made while the count at address 3 is below 4 raises a reset request at the next clock edge.
- R9: A key write made while the count is 4 or more returns the count to 0, and the watchdog keeps running.
- R10: A reset request is high for exactly 4 cycles. After it ends the watchdog is idle, and status bit 2 is set. Status bit 2 is cleared by writing a 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Tick interrupt |
| wake_o | output | 1 | Wake request pulse |
| wdt_rst_o | output | 1 | Watchdog reset request |

## Verification
If the divider state is wrong, the spacing between wake pulses is wrong. A wrong tap shows up after two pulses, at most 65536 cycles later. If the watchdog count is wrong, the count read at address 3 shows it at once. The service window also moves: a key write can raise a reset it should not, or a missed deadline can fail to raise one, within one 16-tick timeout. If the running bit or the pulse counter is wrong, status bit 1 shows the wrong value, or the reset request has the wrong length, within a few cycles of the error.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_STAT  = 2'd1,
    A_START = 2'd2,
    A_SVC   = 2'd3
  } rtw_addr_e;
endpackage

// File: rtl/rtw_prescaler.sv
module rtw_prescaler #(
  parameter int TAP_BASE = 7,
  parameter int SEL_W    = 3,
  parameter int WD_SEL   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic             wd_tick_o
);
  localparam int NTAP  = 1 << SEL_W;
  localparam int DIV_W = TAP_BASE + NTAP;

  logic [DIV_W-1:0] div_q;
  logic [NTAP-1:0]  tap_hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;

  // tap k fires when the low TAP_BASE+k+1 bits are all ones
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap_hit[k] = &div_q[TAP_BASE+k:0];
  end

  assign tick_o    = tap_hit[sel_i];
  assign wd_tick_o = tap_hit[WD_SEL];

  p_tick_spaced_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_tick_o |=> !wd_tick_o);
endmodule

// File: rtl/rtw_tick_flag.sv
module rtw_tick_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;

  p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/rtw_wdog.sv
module rtw_wdog #(
  parameter int          DATA_W  = 8,
  parameter int          TMO     = 16,
  parameter int          RST_CYC = 4,
  parameter logic [7:0]  SVC_KEY = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              svc_we_i,
  input  logic [DATA_W-1:0] svc_data_i,
  output logic              running_o,
  output logic              rst_req_o,
  output logic              err_o,
  output logic [$clog2(TMO+1)-1:0] cnt_o
);
  localparam int CNT_W = $clog2(TMO + 1);
  localparam int PW_W  = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO - 1);
  localparam logic [CNT_W-1:0] LOW  = CNT_W'(TMO / 4);
  localparam logic [PW_W-1:0]  PW_INIT = PW_W'(RST_CYC - 1);
  localparam logic [DATA_W-1:0] KEY = DATA_W'(SVC_KEY);

  logic             running_q, rst_req_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW_W-1:0]  pw_q;
  logic             key_ok, svc_ok, svc_bad, expire;

  assign key_ok  = (svc_data_i == KEY);
  assign svc_ok  = running_q && svc_we_i && key_ok && (cnt_q >= LOW);
  assign svc_bad = running_q && svc_we_i && !(key_ok && (cnt_q >= LOW));
  assign expire  = running_q && !svc_we_i && tick_i && (cnt_q == LAST);
  assign err_o   = svc_bad || expire;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (err_o) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (running_q) begin
      if (svc_ok)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end else if (start_i && !rst_req_q) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      pw_q      <= '0;
    end else if (err_o) begin
      rst_req_q <= 1'b1;
      pw_q      <= PW_INIT;
    end else if (rst_req_q) begin
      if (pw_q == '0) rst_req_q <= 1'b0;
      else            pw_q      <= pw_q - 1'b1;
    end

  assign running_o = running_q;
  assign rst_req_o = rst_req_q;
  assign cnt_o     = cnt_q;

  p_wrong_key_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && svc_we_i && svc_data_i != KEY) |=> rst_req_q);
  p_keep_running_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !svc_we_i && !(tick_i && cnt_q == LAST)) |=> running_q);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TMO));
  p_idle_after_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_q) |-> !running_q);
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
  import rtw_pkg::*;
#(
  parameter int         TAP_BASE = 7,
  parameter int         SEL_W    = 3,
  parameter int         WD_SEL   = 0,
  parameter int         TMO      = 16,
  parameter int         RST_CYC  = 4,
  parameter logic [7:0] SVC_KEY  = 8'hA5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       wake_o,
  output logic       wdt_rst_o
);
  localparam int CNT_W = $clog2(TMO + 1);

  logic [SEL_W-1:0] sel_q;
  logic             irq_en_q, wake_en_q, wake_q, cause_q;
  logic             tick, wd_tick, flag, running, wd_err;
  logic [CNT_W-1:0] wd_cnt;
  rtw_addr_e        addr;

  assign addr = rtw_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sel_q     <= '0;
      irq_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
    end else if (we_i && addr == A_CTRL) begin
      sel_q     <= wdata_i[SEL_W-1:0];
      irq_en_q  <= wdata_i[3];
      wake_en_q <= wdata_i[4];
    end

  rtw_prescaler #(.TAP_BASE(TAP_BASE), .SEL_W(SEL_W), .WD_SEL(WD_SEL)) u_pre (
    .clk_i, .rst_ni, .sel_i(sel_q), .tick_o(tick), .wd_tick_o(wd_tick)
  );

  rtw_tick_flag u_flag (
    .clk_i, .rst_ni, .set_i(tick),
    .clr_i(we_i && addr == A_STAT && wdata_i[0]), .flag_o(flag)
  );

  rtw_wdog #(.DATA_W(8), .TMO(TMO), .RST_CYC(RST_CYC), .SVC_KEY(SVC_KEY)) u_wd (
    .clk_i, .rst_ni, .tick_i(wd_tick),
    .start_i(we_i && addr == A_START && wdata_i[0]),
    .svc_we_i(we_i && addr == A_SVC), .svc_data_i(wdata_i),
    .running_o(running), .rst_req_o(wdt_rst_o), .err_o(wd_err), .cnt_o(wd_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wake_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      wake_q <= tick && wake_en_q;
      if (wd_err)                                        cause_q <= 1'b1;
      else if (we_i && addr == A_STAT && wdata_i[2])     cause_q <= 1'b0;
    end

  assign wake_o = wake_q;
  assign irq_o  = flag && irq_en_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_CTRL:  begin
        rdata_o[SEL_W-1:0] = sel_q;
        rdata_o[3]         = irq_en_q;
        rdata_o[4]         = wake_en_q;
      end
      A_STAT:  rdata_o[2:0] = {cause_q, running, flag};
      A_START: rdata_o = '0;
      A_SVC:   rdata_o[CNT_W-1:0] = wd_cnt;
    endcase
  end

  p_wake_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_cause_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> cause_q);
endmodule

// File: tb/rtc_wdog_bench.sv
module rtc_wdog_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wake, wrst;
  int         errors = 0, checks = 0;
  bit         done = 0;

  rtc_wdog u_rtc_wdog (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wake_o(wake), .wdt_rst_o(wrst)
  );

  always #2.5 clk = ~clk;

  function automatic int exp_period(int sel);
    return 1 << (8 + sel);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // count cycles until wrst is seen high, giving up after lim
  task automatic wait_rst(int lim, output int n);
    n = 0;
    while (!wrst && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic quiet(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (wrst) hits++; end
  endtask

  task automatic measure(int sel);
    int n;
    wr(2'd0, 8'h10 | 8'(sel));
    while (!wake) @(negedge clk);
    @(negedge clk);
    while (!wake) @(negedge clk);
    n = 0;
    @(negedge clk);
    while (!wake) begin @(negedge clk); n++; end
    check("R1 tick period", n + 1, exp_period(sel));
  endtask

  task automatic finish_pulse(output int width);
    width = 0;
    while (wrst) begin @(negedge clk); width++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n, hits, w;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(2'd1, d);   check("R4 idle after reset", d[1], 0);
    check("R3 flag clear after reset", d[0], 0);
    check("R10 cause clear after reset", d[2], 0);
    check("R7 no reset request", wrst, 0);

    // R4: service writes ignored while idle
    wr(2'd3, 8'h3C);
    quiet(20, hits); check("R4 idle svc ignored", hits, 0);
    rd(2'd3, d);     check("R4 count stays 0", d, 0);
    wr(2'd2, 8'h00);
    rd(2'd1, d);     check("R5 start bit0=0 no start", d[1], 0);

    // R1/R2: tick periods
    measure(0); measure(1); measure(2);
    measure(int'($urandom_range(1, 3)));
    measure(7);

    // R2: wake disabled
    wr(2'd0, 8'h00);
    n = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (wake) n++; end
    check("R2 wake gated off", n, 0);

    // R3: sticky flag, irq gating, W1C
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h01);
    n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    check("R3 irq after tick", irq, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R3 write 0 keeps flag", d[0], 1);
    wr(2'd0, 8'h00);
    check("R3 irq masked", irq, 0);
    wr(2'd1, 8'h01);
    rd(2'd1, d); check("R3 W1C clears flag", d[0], 0);

    // R6: timeout after 16 ticks
    wr(2'd2, 8'h01);
    rd(2'd1, d); check("R5 started", d[1], 1);
    quiet(15 * 256 - 8, hits); check("R6 no early expiry", hits, 0);
    wait_rst(400, n); check("R6 expiry raises reset", wrst, 1);
    finish_pulse(w); check("R10 pulse width", w, 4);
    rd(2'd1, d); check("R10 idle after pulse", d[1], 0);
    check("R10 cause set", d[2], 1);
    wr(2'd1, 8'h04);
    rd(2'd1, d); check("R10 cause W1C", d[2], 0);

    // R8: early service
    wr(2'd2, 8'h01);
    wr(2'd3, 8'hA5);
    wait_rst(3, n); check("R8 early key is error", wrst, 1);
    finish_pulse(w); check("R10 pulse width early", w, 4);

    // R9/R5: valid services keep it running
    wr(2'd2, 8'h01);
    for (int k = 0; k < 5; k++) begin
      quiet(int'($urandom_range(1100, 3400)), hits);
      check("R9 no reset inside window", hits, 0);
      wr(2'd3, 8'hA5);
      rd(2'd3, d); check("R9 count cleared", int'(d <= 1), 1);
      wr(2'd2, 8'h00);
      rd(2'd1, d); check("R5 still running", d[1], 1);
    end

    // R7: wrong key
    for (int k = 0; k < 3; k++) begin
      quiet(1100, hits);
      d = 8'($urandom_range(0, 255));
      if (d == 8'hA5) d = 8'h5A;
      wr(2'd3, d);
      wait_rst(3, n); check("R7 wrong key raises reset", wrst, 1);
      finish_pulse(w); check("R10 pulse width key", w, 4);
      rd(2'd1, d); check("R10 idle after key error", d[1], 0);
      wr(2'd2, 8'h01);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule